// File: doc/BRIEF.md
# Phase-Comparator Distance Element

This block evaluates one distance-protection element once per protection pass. At each pass strobe it takes rectangular fixed-point phasors for the loop current, the loop voltage, the zero- and negative-sequence currents and the positive-sequence memory voltage. It also takes a complex replica impedance, a reach multiplier and a minimum polarizing magnitude. From these it forms the replica-impedance products and the operating quantity (k·I·Z − V). It then runs three kinds of phase comparator: a memory-polarized dynamic mho, a self-tilting reactance line and sequence-current directional supervision.

A comparator picks up when its operating phasor lies within ±90° of its polarizing phasor. The test is the sign of Re(A·conj(B)), so no angle is computed. A mode input selects the ground or the phase variant of the element. The reach multiplier scales only the mho and reactance operating quantity. The directional comparators always use the full replica impedance.

One shared complex multiplier and one shared dot-product comparator are stepped by a state machine with these states: IDLE, MUL_IZ, MUL_I0, MUL_I2, SCALE, CMP_MHO, CMP_REAC, CMP_DIRZ, CMP_DIRN and PUBLISH. The transitions are:
- IDLE→MUL_IZ on an accepted strobe.
- MUL_IZ→MUL_I0 in ground mode, and MUL_IZ→SCALE in phase mode.
- MUL_I0→MUL_I2→SCALE.
- SCALE→CMP_MHO→CMP_REAC→CMP_DIRZ.
- CMP_DIRZ→CMP_DIRN in ground mode, and CMP_DIRZ→PUBLISH in phase mode.
- CMP_DIRN→PUBLISH.
- PUBLISH→IDLE.

Top module: `distance_phcmp`

## Requirements
- R1: After reset, all pickup outputs, `elem_op` and `pass_done` are 0.
- R2: Products of current and replica impedance are formed per component and shifted right arithmetically by ZF bits, flooring the result: IZ = ((Ir·Zr − Ii·Zi)>>>ZF, (Ir·Zi + Ii·Zr)>>>ZF). The operating quantity is OP = ((IZ·K)>>>KF) − V per component, where K is unsigned and 2^KF represents 1.0. The mho picks up when Re(OP·conj(VM)) ≥ 0, and a dot product of exactly zero picks up.
- R3: The reactance comparator tests OP against I0·Z in ground mode (`gnd_mode`=1) and against I·Z at full reach in phase mode (`gnd_mode`=0).
- R4: In ground mode, `pk_dirz` tests I0·Z against VM and `pk_dirn` tests I2·Z against VM, both without the reach multiplier.
- R5: In phase mode, `pk_dirz` tests I·Z at full reach against VM, and `pk_dirn` is 0.
- R6: A comparator whose polarizing phasor B satisfies Br²+Bi² < `pol_min`² does not pick up. Equality does not block the pickup.
- R7: `elem_op` is the AND of `pk_mho`, `pk_reac`, `pk_dirz` and, in ground mode only, `pk_dirn`.
- R8: `pass_done` is a one-cycle pulse. It occurs 9 rising edges after the strobe-accepting edge in ground mode and 6 in phase mode. The outputs change only together with that pulse.
- R9: Inputs are captured only on the edge that accepts a strobe in IDLE. A strobe or input change while a pass is in progress has no effect on the result and starts no extra pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_stb | input | 1 | Protection-pass strobe |
| gnd_mode | input | 1 | 1 = ground element, 0 = phase element |
| i_re | input | W | Loop current, real part |
| i_im | input | W | Loop current, imaginary part |
| v_re | input | W | Loop voltage, real part |
| v_im | input | W | Loop voltage, imaginary part |
| i0_re | input | W | Zero-sequence current, real part |
| i0_im | input | W | Zero-sequence current, imaginary part |
| i2_re | input | W | Negative-sequence current, real part |
| i2_im | input | W | Negative-sequence current, imaginary part |
| vm_re | input | W | Positive-sequence memory voltage, real part |
| vm_im | input | W | Positive-sequence memory voltage, imaginary part |
| z_re | input | ZW | Replica impedance, real part, ZF fraction bits |
| z_im | input | ZW | Replica impedance, imaginary part, ZF fraction bits |
| reach_k | input | KW | Unsigned reach multiplier, KF fraction bits |
| pol_min | input | W | Minimum polarizing magnitude |
| pk_mho | output | 1 | Mho comparator pickup |
| pk_reac | output | 1 | Reactance comparator pickup |
| pk_dirz | output | 1 | Zero-sequence (ground) or phase directional pickup |
| pk_dirn | output | 1 | Negative-sequence directional pickup (ground only) |
| elem_op | output | 1 | Element operate |
| pass_done | output | 1 | Results updated this cycle |

## Verification
The hardest case to reach is a comparator sitting exactly on its boundary. This means a dot product of exactly zero, or a polarizing magnitude exactly equal to the minimum, and it must come after the floored impedance and reach shifts. Directed passes reach it by zeroing the loop current, so that the operating quantity is −V, and by using a 3-4-5 memory voltage against a minimum of 5 and then 6. A second hard case is a strobe arriving mid-pass. The stimulus raises it two cycles into a pass, with scrambled inputs, and then watches for a stray second completion.

// File: rtl/dist_elem_pkg.sv
`timescale 1ns/1ps
package dist_elem_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MUL_IZ,
        ST_MUL_I0,
        ST_MUL_I2,
        ST_SCALE,
        ST_CMP_MHO,
        ST_CMP_REAC,
        ST_CMP_DIRZ,
        ST_CMP_DIRN,
        ST_PUBLISH
    } pass_state_e;
endpackage

// File: rtl/dist_cmul.sv
`timescale 1ns/1ps
// Complex multiply at full precision followed by a floor shift and truncation.
module dist_cmul #(
    parameter int AW = 18,
    parameter int BW = 18,
    parameter int SH = 10,
    parameter int OW = 27
) (
    input  logic signed [AW-1:0] ar,
    input  logic signed [AW-1:0] ai,
    input  logic signed [BW-1:0] br,
    input  logic signed [BW-1:0] bi,
    output logic signed [OW-1:0] pr,
    output logic signed [OW-1:0] pi
);
    localparam int FW = AW + BW + 1;

    logic signed [FW-1:0] xar, xai, xbr, xbi, fr, fi;

    always_comb begin
        xar = FW'(ar);
        xai = FW'(ai);
        xbr = FW'(br);
        xbi = FW'(bi);
        fr  = xar * xbr - xai * xbi;
        fi  = xar * xbi + xai * xbr;
        pr  = OW'(fr >>> SH);
        pi  = OW'(fi >>> SH);
    end
endmodule

// File: rtl/dist_dotcmp.sv
`timescale 1ns/1ps
// Phase comparator: picks up when Re(A*conj(B)) >= 0 and |B|^2 >= min^2.
module dist_dotcmp #(
    parameter int QW = 31,
    parameter int MW = 18
) (
    input  logic signed [QW-1:0] a_re,
    input  logic signed [QW-1:0] a_im,
    input  logic signed [QW-1:0] b_re,
    input  logic signed [QW-1:0] b_im,
    input  logic        [MW-1:0] pol_min,
    output logic                 pick
);
    localparam int DW = 2 * QW + 1;

    logic signed [DW-1:0] xar, xai, xbr, xbi, dot, mag, mn, mn2;

    always_comb begin
        xar  = DW'(a_re);
        xai  = DW'(a_im);
        xbr  = DW'(b_re);
        xbi  = DW'(b_im);
        dot  = xar * xbr + xai * xbi;
        mag  = xbr * xbr + xbi * xbi;
        mn   = DW'(signed'({1'b0, pol_min}));
        mn2  = mn * mn;
        pick = !dot[DW-1] && (mag >= mn2);
    end
endmodule

// File: rtl/dist_pass_ctrl.sv
`timescale 1ns/1ps
module dist_pass_ctrl
    import dist_elem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pass_stb,
    input  logic        gnd_q,
    output pass_state_e state
);
    pass_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = pass_stb ? ST_MUL_IZ : ST_IDLE;
            ST_MUL_IZ:   nxt = gnd_q ? ST_MUL_I0 : ST_SCALE;
            ST_MUL_I0:   nxt = ST_MUL_I2;
            ST_MUL_I2:   nxt = ST_SCALE;
            ST_SCALE:    nxt = ST_CMP_MHO;
            ST_CMP_MHO:  nxt = ST_CMP_REAC;
            ST_CMP_REAC: nxt = ST_CMP_DIRZ;
            ST_CMP_DIRZ: nxt = gnd_q ? ST_CMP_DIRN : ST_PUBLISH;
            ST_CMP_DIRN: nxt = ST_PUBLISH;
            ST_PUBLISH:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // R9: a pass in progress is never restarted by a strobe
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_MUL_IZ));

    // R5: phase passes never visit the sequence-current states
    a_r5_phase_skips_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUL_I0 || state == ST_MUL_I2 || state == ST_CMP_DIRN) |-> gnd_q);
endmodule

// File: rtl/distance_phcmp.sv
`timescale 1ns/1ps
module distance_phcmp
    import dist_elem_pkg::*;
#(
    parameter int W  = 18,
    parameter int ZW = 18,
    parameter int ZF = 10,
    parameter int KW = 16,
    parameter int KF = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pass_stb,
    input  logic                 gnd_mode,
    input  logic signed [W-1:0]  i_re,
    input  logic signed [W-1:0]  i_im,
    input  logic signed [W-1:0]  v_re,
    input  logic signed [W-1:0]  v_im,
    input  logic signed [W-1:0]  i0_re,
    input  logic signed [W-1:0]  i0_im,
    input  logic signed [W-1:0]  i2_re,
    input  logic signed [W-1:0]  i2_im,
    input  logic signed [W-1:0]  vm_re,
    input  logic signed [W-1:0]  vm_im,
    input  logic signed [ZW-1:0] z_re,
    input  logic signed [ZW-1:0] z_im,
    input  logic        [KW-1:0] reach_k,
    input  logic        [W-1:0]  pol_min,
    output logic                 pk_mho,
    output logic                 pk_reac,
    output logic                 pk_dirz,
    output logic                 pk_dirn,
    output logic                 elem_op,
    output logic                 pass_done
);
    localparam int PW = W + ZW + 1 - ZF;       // impedance-product width
    localparam int QW = PW + KW - KF + 2;      // operating-quantity width

    pass_state_e state;

    // captured pass inputs
    logic signed [W-1:0]  ir_q, ii_q, vr_q, vi_q, i0r_q, i0i_q, i2r_q, i2i_q, vmr_q, vmi_q;
    logic signed [ZW-1:0] zr_q, zi_q;
    logic        [KW-1:0] k_q;
    logic        [W-1:0]  pm_q;
    logic                 gnd_q;

    // intermediate quantities
    logic signed [PW-1:0] izr_q, izi_q, i0zr_q, i0zi_q, i2zr_q, i2zi_q;
    logic signed [QW-1:0] opr_q, opi_q;
    logic                 f_mho, f_reac, f_dirz, f_dirn;

    dist_pass_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass_stb (pass_stb),
        .gnd_q    (gnd_q),
        .state    (state)
    );

    // shared impedance multiplier
    logic signed [W-1:0]  ma_re, ma_im;
    logic signed [PW-1:0] prod_re, prod_im;

    always_comb begin
        case (state)
            ST_MUL_I0: begin ma_re = i0r_q; ma_im = i0i_q; end
            ST_MUL_I2: begin ma_re = i2r_q; ma_im = i2i_q; end
            default:   begin ma_re = ir_q;  ma_im = ii_q;  end
        endcase
    end

    dist_cmul #(.AW(W), .BW(ZW), .SH(ZF), .OW(PW)) u_zmul (
        .ar (ma_re), .ai (ma_im),
        .br (zr_q),  .bi (zi_q),
        .pr (prod_re), .pi (prod_im)
    );

    // reach scaling as a complex multiply by (K + j0)
    logic signed [KW:0]   k_s;
    logic signed [KW:0]   k_zero;
    logic signed [QW-1:0] sc_re, sc_im;

    assign k_s    = signed'({1'b0, k_q});
    assign k_zero = '0;

    dist_cmul #(.AW(PW), .BW(KW + 1), .SH(KF), .OW(QW)) u_kmul (
        .ar (izr_q), .ai (izi_q),
        .br (k_s),   .bi (k_zero),
        .pr (sc_re), .pi (sc_im)
    );

    // shared phase comparator
    logic signed [QW-1:0] ca_re, ca_im, cb_re, cb_im;
    logic                 cmp_pick;

    always_comb begin
        ca_re = opr_q;
        ca_im = opi_q;
        cb_re = QW'(vmr_q);
        cb_im = QW'(vmi_q);
        case (state)
            ST_CMP_REAC: begin
                cb_re = gnd_q ? QW'(i0zr_q) : QW'(izr_q);
                cb_im = gnd_q ? QW'(i0zi_q) : QW'(izi_q);
            end
            ST_CMP_DIRZ: begin
                ca_re = gnd_q ? QW'(i0zr_q) : QW'(izr_q);
                ca_im = gnd_q ? QW'(i0zi_q) : QW'(izi_q);
            end
            ST_CMP_DIRN: begin
                ca_re = QW'(i2zr_q);
                ca_im = QW'(i2zi_q);
            end
            default: ;
        endcase
    end

    dist_dotcmp #(.QW(QW), .MW(W)) u_cmp (
        .a_re (ca_re), .a_im (ca_im),
        .b_re (cb_re), .b_im (cb_im),
        .pol_min (pm_q),
        .pick (cmp_pick)
    );

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;  ii_q <= '0;  vr_q <= '0;  vi_q <= '0;
            i0r_q <= '0; i0i_q <= '0; i2r_q <= '0; i2i_q <= '0;
            vmr_q <= '0; vmi_q <= '0; zr_q <= '0;  zi_q <= '0;
            k_q <= '0;   pm_q <= '0;  gnd_q <= 1'b0;
            izr_q <= '0;  izi_q <= '0;  i0zr_q <= '0; i0zi_q <= '0;
            i2zr_q <= '0; i2zi_q <= '0; opr_q <= '0;  opi_q <= '0;
            f_mho <= 1'b0; f_reac <= 1'b0; f_dirz <= 1'b0; f_dirn <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (pass_stb) begin
                    ir_q <= i_re;   ii_q <= i_im;   vr_q <= v_re;   vi_q <= v_im;
                    i0r_q <= i0_re; i0i_q <= i0_im; i2r_q <= i2_re; i2i_q <= i2_im;
                    vmr_q <= vm_re; vmi_q <= vm_im; zr_q <= z_re;   zi_q <= z_im;
                    k_q <= reach_k; pm_q <= pol_min; gnd_q <= gnd_mode;
                end
                ST_MUL_IZ:   begin izr_q  <= prod_re; izi_q  <= prod_im; end
                ST_MUL_I0:   begin i0zr_q <= prod_re; i0zi_q <= prod_im; end
                ST_MUL_I2:   begin i2zr_q <= prod_re; i2zi_q <= prod_im; end
                ST_SCALE:    begin
                    opr_q <= sc_re - QW'(vr_q);
                    opi_q <= sc_im - QW'(vi_q);
                end
                ST_CMP_MHO:  f_mho  <= cmp_pick;
                ST_CMP_REAC: f_reac <= cmp_pick;
                ST_CMP_DIRZ: f_dirz <= cmp_pick;
                ST_CMP_DIRN: f_dirn <= cmp_pick;
                ST_PUBLISH:  ;
                default:     ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_mho <= 1'b0; pk_reac <= 1'b0; pk_dirz <= 1'b0; pk_dirn <= 1'b0;
            elem_op <= 1'b0; pass_done <= 1'b0;
        end else if (state == ST_PUBLISH) begin
            pk_mho    <= f_mho;
            pk_reac   <= f_reac;
            pk_dirz   <= f_dirz;
            pk_dirn   <= gnd_q & f_dirn;
            elem_op   <= f_mho & f_reac & f_dirz & (f_dirn | ~gnd_q);
            pass_done <= 1'b1;
        end else begin
            pass_done <= 1'b0;
        end
    end

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R8: results hold between completions
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_done |-> $stable({pk_mho, pk_reac, pk_dirz, pk_dirn, elem_op}));

    // R7: operate requires the three always-used pickups
    a_r7_and: assert property (@(posedge clk) disable iff (!rst_n)
        elem_op |-> (pk_mho && pk_reac && pk_dirz));

    // R5: no negative-sequence pickup reported for a phase pass
    a_r5_dirn_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_done && !gnd_q) |-> !pk_dirn);
endmodule

// File: tb/tb_distance_phcmp.sv
`timescale 1ns/1ps
module tb_distance_phcmp;
    localparam int W  = 18;
    localparam int ZW = 18;
    localparam int ZF = 10;
    localparam int KW = 16;
    localparam int KF = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pass_stb = 1'b0;
    logic gnd_mode = 1'b0;
    logic signed [W-1:0] i_re = '0, i_im = '0, v_re = '0, v_im = '0;
    logic signed [W-1:0] i0_re = '0, i0_im = '0, i2_re = '0, i2_im = '0;
    logic signed [W-1:0] vm_re = '0, vm_im = '0;
    logic signed [ZW-1:0] z_re = '0, z_im = '0;
    logic [KW-1:0] reach_k = '0;
    logic [W-1:0]  pol_min = '0;
    logic pk_mho, pk_reac, pk_dirz, pk_dirn, elem_op, pass_done;

    always #5 clk = ~clk;

    distance_phcmp #(.W(W), .ZW(ZW), .ZF(ZF), .KW(KW), .KF(KF)) dut (
        .clk(clk), .rst_n(rst_n), .pass_stb(pass_stb), .gnd_mode(gnd_mode),
        .i_re(i_re), .i_im(i_im), .v_re(v_re), .v_im(v_im),
        .i0_re(i0_re), .i0_im(i0_im), .i2_re(i2_re), .i2_im(i2_im),
        .vm_re(vm_re), .vm_im(vm_im), .z_re(z_re), .z_im(z_im),
        .reach_k(reach_k), .pol_min(pol_min),
        .pk_mho(pk_mho), .pk_reac(pk_reac), .pk_dirz(pk_dirz), .pk_dirn(pk_dirn),
        .elem_op(elem_op), .pass_done(pass_done)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    longint g_ir, g_ii, g_vr, g_vi, g_0r, g_0i, g_2r, g_2i, g_mr, g_mi, g_zr, g_zi, g_k, g_pm;
    bit g_gnd;
    bit e_mho, e_reac, e_dirz, e_dirn, e_elem;

    task automatic chk(input bit got, input bit exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string tag);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit pick(input longint ar, input longint ai,
                                input longint br, input longint bi, input longint pm);
        return ((ar * br + ai * bi) >= 0) && ((br * br + bi * bi) >= pm * pm);
    endfunction

    task automatic model();
        longint izr, izi, i0zr, i0zi, i2zr, i2zi, opr, opi;
        izr  = (g_ir * g_zr - g_ii * g_zi) >>> ZF;
        izi  = (g_ir * g_zi + g_ii * g_zr) >>> ZF;
        i0zr = (g_0r * g_zr - g_0i * g_zi) >>> ZF;
        i0zi = (g_0r * g_zi + g_0i * g_zr) >>> ZF;
        i2zr = (g_2r * g_zr - g_2i * g_zi) >>> ZF;
        i2zi = (g_2r * g_zi + g_2i * g_zr) >>> ZF;
        opr  = ((izr * g_k) >>> KF) - g_vr;
        opi  = ((izi * g_k) >>> KF) - g_vi;
        e_mho  = pick(opr, opi, g_mr, g_mi, g_pm);
        e_reac = g_gnd ? pick(opr, opi, i0zr, i0zi, g_pm) : pick(opr, opi, izr, izi, g_pm);
        e_dirz = g_gnd ? pick(i0zr, i0zi, g_mr, g_mi, g_pm) : pick(izr, izi, g_mr, g_mi, g_pm);
        e_dirn = g_gnd ? pick(i2zr, i2zi, g_mr, g_mi, g_pm) : 1'b0;
        e_elem = e_mho & e_reac & e_dirz & (g_gnd ? e_dirn : 1'b1);
    endtask

    task automatic drive(input bit scramble);
        longint s;
        s = scramble ? -1 : 1;
        i_re = W'(s * g_ir);  i_im = W'(s * g_ii);  v_re = W'(s * g_vr);  v_im = W'(s * g_vi);
        i0_re = W'(s * g_0r); i0_im = W'(s * g_0i); i2_re = W'(s * g_2r); i2_im = W'(s * g_2i);
        vm_re = W'(s * g_mr); vm_im = W'(s * g_mi);
        z_re = ZW'(s * g_zr); z_im = ZW'(s * g_zi);
        reach_k = scramble ? KW'(g_k + 5000) : KW'(g_k);
        pol_min = scramble ? W'(g_pm + 7) : W'(g_pm);
        gnd_mode = scramble ? ~g_gnd : g_gnd;
    endtask

    task automatic run_pass(input bit busy);
        int cnt;
        int extra;
        bit h_mho, h_reac, h_dirz, h_dirn, h_elem;
        model();
        @(negedge clk);
        drive(1'b0);
        pass_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pass_stb = 1'b0;
        cnt = 0;
        while (!pass_done && cnt < 40) begin
            if (busy && cnt == 2) begin
                pass_stb = 1'b1;
                drive(1'b1);
            end else begin
                pass_stb = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        pass_stb = 1'b0;
        chk_int(cnt, g_gnd ? 9 : 6, "R8 completion latency");
        chk(pk_mho,  e_mho,  "R2 mho pickup");
        chk(pk_reac, e_reac, "R3 reactance pickup");
        chk(pk_dirz, e_dirz, g_gnd ? "R4 zero-seq directional" : "R5 phase directional");
        chk(pk_dirn, e_dirn, g_gnd ? "R4 neg-seq directional" : "R5 neg-seq low in phase");
        chk(elem_op, e_elem, "R7 element operate");
        h_mho = pk_mho; h_reac = pk_reac; h_dirz = pk_dirz; h_dirn = pk_dirn; h_elem = elem_op;
        drive(1'b1);
        extra = 0;
        for (int c = 0; c < (busy ? 15 : 3); c++) begin
            @(posedge clk);
            @(negedge clk);
            if (pass_done) extra++;
        end
        chk({pk_mho, pk_reac, pk_dirz, pk_dirn, elem_op} == {h_mho, h_reac, h_dirz, h_dirn, h_elem},
            1'b1, "R8 outputs hold without strobe");
        if (busy) chk_int(extra, 0, "R9 mid-pass strobe starts no pass");
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({pk_mho, pk_reac, pk_dirz, pk_dirn, elem_op, pass_done} == 6'b0, 1'b1, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk({pk_mho, pk_reac, pk_dirz, pk_dirn, elem_op, pass_done} == 6'b0, 1'b1, "R1 idle after reset");

        // R2 boundary: zero current, dot product exactly zero
        g_gnd = 1'b0; g_ir = 0; g_ii = 0; g_vr = 50; g_vi = 0;
        g_0r = 0; g_0i = 0; g_2r = 0; g_2i = 0; g_mr = 0; g_mi = 40;
        g_zr = 1024; g_zi = 2048; g_k = 16384; g_pm = 0;
        run_pass(1'b0);
        chk(pk_mho, 1'b1, "R2 zero dot product picks up");

        // R6 boundary: |VM| = 5 against minimum 5 (passes) and 6 (blocks)
        g_gnd = 1'b1; g_vr = -30; g_vi = -40; g_mr = 3; g_mi = 4;
        g_0r = 20; g_0i = 0; g_2r = 20; g_2i = 0; g_pm = 5;
        run_pass(1'b0);
        chk(pk_mho, 1'b1, "R6 equal magnitude does not block");
        g_pm = 6;
        run_pass(1'b0);
        chk(pk_mho, 1'b0, "R6 weak polarizing blocks mho");
        chk(pk_dirz, 1'b0, "R6 weak polarizing blocks directional");

        // R9: strobe and input change mid-pass, both modes
        g_ir = 40; g_ii = -10; g_vr = 20; g_vi = 15; g_pm = 0; g_k = 12000;
        run_pass(1'b1);
        g_gnd = 1'b0;
        run_pass(1'b1);

        // near-exhaustive sweep over mode, current, voltage, memory and reach
        for (int g = 0; g < 2; g++)
            for (int a = -2; a <= 2; a++)
                for (int b = -2; b <= 2; b++)
                    for (int c = -2; c <= 2; c++)
                        for (int d = 0; d < 3; d++) begin
                            g_gnd = (g == 1);
                            g_ir = a * 40 + 7;  g_ii = 25 - a * 20;
                            g_vr = b * 60;      g_vi = 40 - b * 30;
                            g_0r = c * 30 - 10; g_0i = a * 20 + c * 10;
                            g_2r = b * 25 + 5;  g_2i = a * 5 - c * 35;
                            g_mr = c * 10;      g_mi = 15 - c * 5 + b * 3;
                            g_zr = 1024 + g * 512; g_zi = 2048 - g * 2560;
                            g_k  = (d == 0) ? 8192 : ((d == 1) ? 16384 : 24576);
                            g_pm = d * 24;
                            run_pass(1'b0);
                        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule